// File: doc/BRIEF.md
# Flash Read Data Selector

This block forms the data word returned by a parallel NOR-style flash model on every read. A command sequencer elsewhere tracks the write cycles and reports which mode the device is in. From that mode, the block chooses among four sources: plain array contents, identification bytes, the status byte, and bytes from a small common-flash-interface query ROM. The array storage supplies up to four bytes that start at the read address, in address order. This block packs them into a word of the requested access width, in either byte order.

For identification and query reads, the low byte of the offset is first scaled down by the device bus width. Each location then has the same index on 8-, 16- and 32-bit parts. A mode code the block does not recognise still returns array data. It also pulses a request that tells the sequencer to return to its idle state. The result is registered: it changes on the clock edge after a read strobe and holds between strobes.

Top module: `flash_rd_mux`

## Requirements
- R1: While reset is active, and after it is released, `rd_data` is zero and `seq_rst_req` is low until the first read strobe.
- R2: `rd_data` takes its new value on the rising edge that samples `rd_en` high. It holds its value on every edge where `rd_en` is low, whatever the other inputs do.
- R3: In mode 0 (array) and mode 1 (unlock in progress), the read returns array data built from `arr_bytes`, where byte k sits at bits [8k+7:8k] and is at address offset+k. With `acc_w` 1 (two bytes), big-endian gives {b0,b1} and little-endian gives {b1,b0}. With `acc_w` 2 (four bytes), big-endian gives {b0,b1,b2,b3} and little-endian gives {b3,b2,b1,b0}. With `acc_w` 0 or 3, the read gives b0. Unused upper bits are zero.
- R4: The query index is `q_addr` shifted right by 1 when `dev_w` is 1 (16-bit device), shifted right by 2 when `dev_w` is 2 (32-bit device), and left unchanged otherwise.
- R5: In mode 2 (autoselect), index 0x00 returns `id0` and index 0x01 returns `id1`.
- R6: In mode 2, index 0x02 returns 0x00, so every sector reads as unprotected. Any index not named in R5 or R7 also returns 0x00.
- R7: In mode 2, index 0x0E returns `id2` and index 0x0F returns `id3`. When the selected ID is 0xFF, the read returns the array data of R3 instead.
- R8: In mode 3 (status), the read returns `status`, zero-extended.
- R9: In mode 4 (query), indices 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59 ("QRY"). Index 0x13 returns 0x02, and index 0x27 returns CHIP_LOG2.
- R10: In mode 4, any index at or above CFI_LEN returns 0x00.
- R11: A read strobe in modes 5 to 7 returns the array data of R3 and drives `seq_rst_req` high for exactly the next cycle. A strobe in modes 0 to 4 leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe; result registered on this edge |
| mode | input | 3 | Sequencer mode: 0 array, 1 unlock, 2 autoselect, 3 status, 4 query |
| q_addr | input | 8 | Low byte of the read byte offset |
| acc_w | input | 2 | Access width: 0 one byte, 1 two bytes, 2 four bytes |
| dev_w | input | 2 | Device bus width: 0 8-bit, 1 16-bit, 2 32-bit |
| big_end | input | 1 | 1 = most significant byte at the lowest address |
| arr_bytes | input | 32 | Four array bytes starting at the read offset, byte k at bits [8k+7:8k] |
| id0 | input | 8 | Identification byte at index 0x00 |
| id1 | input | 8 | Identification byte at index 0x01 |
| id2 | input | 8 | Identification byte at index 0x0E |
| id3 | input | 8 | Identification byte at index 0x0F |
| status | input | 8 | Status byte |
| rd_data | output | 32 | Registered read word |
| seq_rst_req | output | 1 | One-cycle request for the sequencer to return to idle |

## Verification
Array reads use distinct non-palindromic byte patterns. These are tried under every access width and both byte orders in both array-like modes, so a swapped, dropped or misplaced byte appears as a wrong value. Autoselect and query reads sweep all 256 low-byte offsets under each device width. This separates correct index scaling from off-by-one shifts and finds aliasing of the ID, protection and table locations. The autoselect sweep is run twice, once with the upper IDs set to 0xFF, so that the fallback path is distinguished from the ID path. Unknown mode codes, a status sweep and idle cycles that change inputs without a strobe test the reset request pulse and the hold behaviour.

// File: rtl/flash_rd_mux.sv
module flash_rd_mux #(
  parameter int CFI_LEN   = 61,
  parameter int CHIP_LOG2 = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [2:0]  mode,
  input  logic [7:0]  q_addr,
  input  logic [1:0]  acc_w,
  input  logic [1:0]  dev_w,
  input  logic        big_end,
  input  logic [31:0] arr_bytes,
  input  logic [7:0]  id0,
  input  logic [7:0]  id1,
  input  logic [7:0]  id2,
  input  logic [7:0]  id3,
  input  logic [7:0]  status,
  output logic [31:0] rd_data,
  output logic        seq_rst_req
);

  localparam logic [2:0] M_ARRAY  = 3'd0;
  localparam logic [2:0] M_UNLOCK = 3'd1;
  localparam logic [2:0] M_AUTO   = 3'd2;
  localparam logic [2:0] M_STAT   = 3'd3;
  localparam logic [2:0] M_QUERY  = 3'd4;
  localparam logic [7:0] SIZE_B   = 8'(CHIP_LOG2);

  logic [7:0]  qix;
  logic [7:0]  b0, b1, b2, b3;
  logic [31:0] arr_word;
  logic [31:0] auto_word;
  logic [7:0]  rom_byte;
  logic [31:0] nxt;
  logic        known;

  assign {b3, b2, b1, b0} = arr_bytes;

  always_comb begin
    case (dev_w)
      2'd1:    qix = q_addr >> 1;
      2'd2:    qix = q_addr >> 2;
      default: qix = q_addr;
    endcase
  end

  always_comb begin
    case (acc_w)
      2'd1:    arr_word = big_end ? {16'd0, b0, b1} : {16'd0, b1, b0};
      2'd2:    arr_word = big_end ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
      default: arr_word = {24'd0, b0};
    endcase
  end

  always_comb begin
    case (qix)
      8'h00:   auto_word = {24'd0, id0};
      8'h01:   auto_word = {24'd0, id1};
      8'h0E:   auto_word = (id2 == 8'hFF) ? arr_word : {24'd0, id2};
      8'h0F:   auto_word = (id3 == 8'hFF) ? arr_word : {24'd0, id3};
      default: auto_word = 32'd0;
    endcase
  end

  always_comb begin
    case (qix)
      8'h10: rom_byte = 8'h51;
      8'h11: rom_byte = 8'h52;
      8'h12: rom_byte = 8'h59;
      8'h13: rom_byte = 8'h02;
      8'h15: rom_byte = 8'h31;
      8'h1B: rom_byte = 8'h27;
      8'h1C: rom_byte = 8'h36;
      8'h1F: rom_byte = 8'h07;
      8'h21: rom_byte = 8'h09;
      8'h22: rom_byte = 8'h0C;
      8'h23: rom_byte = 8'h01;
      8'h25: rom_byte = 8'h0A;
      8'h26: rom_byte = 8'h0D;
      8'h27: rom_byte = SIZE_B;
      8'h28: rom_byte = 8'h02;
      8'h2C: rom_byte = 8'h01;
      8'h31: rom_byte = 8'h50;
      8'h32: rom_byte = 8'h52;
      8'h33: rom_byte = 8'h49;
      8'h34: rom_byte = 8'h31;
      8'h35: rom_byte = 8'h30;
      default: rom_byte = 8'h00;
    endcase
    if (int'(qix) >= CFI_LEN) rom_byte = 8'h00;
  end

  assign known = (mode <= M_QUERY);

  always_comb begin
    case (mode)
      M_ARRAY, M_UNLOCK: nxt = arr_word;
      M_AUTO:            nxt = auto_word;
      M_STAT:            nxt = {24'd0, status};
      M_QUERY:           nxt = {24'd0, rom_byte};
      default:           nxt = arr_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data     <= 32'd0;
      seq_rst_req <= 1'b0;
    end else begin
      seq_rst_req <= rd_en && !known;
      if (rd_en) rd_data <= nxt;
    end
  end

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_prot_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && mode == M_AUTO && qix == 8'h02 |=> rd_data == 32'd0);

  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && mode == M_STAT |=> rd_data == {24'd0, $past(status)});

  p_query_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && mode == M_QUERY && int'(qix) >= CFI_LEN |=> rd_data == 32'd0);

  p_req_unknown_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && mode > M_QUERY |=> seq_rst_req);

  p_req_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && mode > M_QUERY) |=> !seq_rst_req);

endmodule

// File: tb/flash_rd_mux_tb.sv
module flash_rd_mux_tb;
  localparam int CFI_LEN   = 61;
  localparam int CHIP_LOG2 = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  q_addr = 8'd0;
  logic [1:0]  acc_w = 2'd0;
  logic [1:0]  dev_w = 2'd0;
  logic        big_end = 1'b0;
  logic [31:0] arr_bytes = 32'd0;
  logic [7:0]  id0 = 8'h01, id1 = 8'h7E, id2 = 8'h22, id3 = 8'h10;
  logic [7:0]  status = 8'h00;
  logic [31:0] rd_data;
  logic        seq_rst_req;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  flash_rd_mux #(.CFI_LEN(CFI_LEN), .CHIP_LOG2(CHIP_LOG2)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .mode(mode), .q_addr(q_addr),
    .acc_w(acc_w), .dev_w(dev_w), .big_end(big_end), .arr_bytes(arr_bytes),
    .id0(id0), .id1(id1), .id2(id2), .id3(id3), .status(status),
    .rd_data(rd_data), .seq_rst_req(seq_rst_req)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_arr(input logic [1:0] w, input logic be, input logic [31:0] a);
    logic [7:0] c0, c1, c2, c3;
    {c3, c2, c1, c0} = a;
    if (w == 2'd1) return be ? {16'd0, c0, c1} : {16'd0, c1, c0};
    if (w == 2'd2) return be ? {c0, c1, c2, c3} : {c3, c2, c1, c0};
    return {24'd0, c0};
  endfunction

  function automatic int shamt(input logic [1:0] d);
    return (d == 2'd1) ? 1 : (d == 2'd2) ? 2 : 0;
  endfunction

  task automatic do_read(input logic [2:0] m, input logic [7:0] qa);
    @(negedge clk);
    mode = m; q_addr = qa; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] pats [8];
    logic [31:0] hold;
    int q;
    int e;
    pats = '{32'h44332211, 32'hA1B2C3D4, 32'h00FF7F80, 32'h0F1E2D3C,
             32'h12345678, 32'hFEDCBA98, 32'h80000001, 32'h5A6B7C8D};

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 data in reset", rd_data, 32'd0);
    check("R1 req in reset", {31'd0, seq_rst_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 data after reset", rd_data, 32'd0);
    check("R1 req after reset", {31'd0, seq_rst_req}, 32'd0);

    // R3 array assembly in both array-like modes
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 4; w++)
        for (int be = 0; be < 2; be++)
          for (int p = 0; p < 8; p++) begin
            acc_w = 2'(w); big_end = 1'(be); arr_bytes = pats[p];
            do_read(3'(m), 8'(p * 37));
            check("R3 array word", rd_data, exp_arr(2'(w), 1'(be), pats[p]));
            check("R11 no req for array", {31'd0, seq_rst_req}, 32'd0);
          end

    // R2 hold without strobe
    hold = rd_data;
    @(negedge clk);
    mode = 3'd3; status = 8'hC3; arr_bytes = 32'hDEADBEEF; q_addr = 8'h55;
    @(negedge clk);
    @(negedge clk);
    check("R2 hold while idle", rd_data, hold);

    // R4 R5 R6 R7 autoselect sweep, with and without 0xFF upper IDs
    for (int ff = 0; ff < 2; ff++) begin
      id2 = ff ? 8'hFF : 8'h22;
      id3 = ff ? 8'hFF : 8'h10;
      for (int d = 0; d < 3; d++)
        for (int a = 0; a < 256; a++) begin
          dev_w = 2'(d); acc_w = 2'(a % 3); big_end = 1'(a[2]);
          arr_bytes = pats[a % 8];
          do_read(3'd2, 8'(a));
          q = a >> shamt(2'(d));
          if (q == 0) check("R5 R4 id0", rd_data, {24'd0, id0});
          else if (q == 1) check("R5 R4 id1", rd_data, {24'd0, id1});
          else if (q == 14)
            check("R7 R4 id2", rd_data, ff ? exp_arr(acc_w, big_end, arr_bytes) : {24'd0, id2});
          else if (q == 15)
            check("R7 R4 id3", rd_data, ff ? exp_arr(acc_w, big_end, arr_bytes) : {24'd0, id3});
          else check("R6 R4 zero index", rd_data, 32'd0);
        end
    end

    // R9 R10 query sweep
    for (int d = 0; d < 3; d++)
      for (int a = 0; a < 256; a++) begin
        dev_w = 2'(d);
        do_read(3'd4, 8'(a));
        q = a >> shamt(2'(d));
        e = -1;
        if (q == 16) e = 8'h51;
        else if (q == 17) e = 8'h52;
        else if (q == 18) e = 8'h59;
        else if (q == 19) e = 8'h02;
        else if (q == 39) e = CHIP_LOG2;
        if (q >= CFI_LEN) check("R10 beyond table", rd_data, 32'd0);
        else if (e >= 0) check("R9 table byte", rd_data, 32'(e));
      end

    // R8 status
    for (int s = 0; s < 256; s += 17) begin
      status = 8'(s);
      do_read(3'd3, 8'(s));
      check("R8 status", rd_data, 32'(s));
    end

    // R11 unknown modes
    for (int m = 5; m < 8; m++)
      for (int p = 0; p < 4; p++) begin
        acc_w = 2'(p % 3); big_end = 1'(p & 1); arr_bytes = pats[p + 4];
        do_read(3'(m), 8'h00);
        check("R11 unknown data", rd_data, exp_arr(acc_w, big_end, arr_bytes));
        check("R11 req raised", {31'd0, seq_rst_req}, 32'd1);
        @(negedge clk);
        check("R11 req one cycle", {31'd0, seq_rst_req}, 32'd0);
      end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule